// File: doc/BRIEF.md
# Stacked General Register Frame Mapper

This block holds 128 general registers of 64 bits each. Every register also has a deferred-token bit (NaT) that marks it as holding no valid data. Logical register numbers from a pipeline are mapped to physical storage under a packed frame marker and a separate frame base.

Logical registers below 32 are static and map one-to-one. Higher logical numbers address a window into a circular pool of 96 stacked physical registers. That window starts at the frame base and is as wide as the marker's frame size. The lowest part of the window can be declared rotating. Its offsets are renamed by a rotation base, and a rotate strobe steps that base down by one.

An access that falls outside the window reads as zero with the NaT bit set and raises an illegal-access flag. A write to such a register is dropped. The block has two combinational read ports, one write port that carries a NaT input, a port that loads the marker and the frame base, and the rotate strobe.

Top module: `gr_frame_map`

## Requirements
- R1: A write stores 64 data bits and the NaT bit into the physical register its logical index maps to. From the next cycle on, both read ports return that data and NaT for any logical index that maps to the same physical register.
- R2: Logical register 0 always reads as zero with NaT 0. A write to it changes nothing.
- R3: Logical registers 1 to 31 map to physical registers 1 to 31. This mapping does not depend on the marker or the frame base.
- R4: A stacked logical register r (r >= 32) has offset o = r - 32. When o is below the frame size (marker bits 6:0) and outside the rotating region, it maps to physical 32 + ((base + o) mod 96). The frame base is loaded in the range 0 to 95.
- R5: The rotating register count is 8 times the code in marker bits 17:14. An offset o below that count is first replaced by (o + rb) mod count, where rb is the rotation base in marker bits 24:18. The frame base is then added as in R4. rb is loaded below the count.
- R6: A read of a stacked register whose offset is at or above the frame size returns zero data with NaT 1. A write to such a register is suppressed. Either access sets illegal_o in the same cycle.
- R7: When the load strobe is high, marker_i and frame_base_i are taken at the clock edge and marker_o shows the new marker from the next cycle. If load and rotate are both high, the load wins.
- R8: A rotate strobe without a load sets the rotation base to rb - 1, or to count - 1 when rb is 0. The other marker bits are kept. With a count of 0 the rotate strobe has no effect.
- R9: After reset every NaT bit is 0, the marker is 0 and the frame base is 0. With a frame size of 0, every stacked register is out of frame.
- R10: A read in the same cycle as a write to the same register returns the value from before the write.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mk_ld_i | input | 1 | Load marker and frame base |
| marker_i | input | 38 | Marker value to load |
| frame_base_i | input | 7 | Frame base to load (0 to 95) |
| rotate_i | input | 1 | Step the rotation base down by one |
| marker_o | output | 38 | Current marker |
| ra_i | input | 7 | Read port A logical index |
| rdata_a_o | output | 64 | Read port A data |
| rnat_a_o | output | 1 | Read port A NaT |
| rb_i | input | 7 | Read port B logical index |
| rdata_b_o | output | 64 | Read port B data |
| rnat_b_o | output | 1 | Read port B NaT |
| we_i | input | 1 | Write enable |
| wa_i | input | 7 | Write logical index |
| wdata_i | input | 64 | Write data |
| wnat_i | input | 1 | Write NaT |
| illegal_o | output | 1 | An enabled access is outside the frame |

## Verification
The bench uses the default build: 64-bit data, 128 registers and 32 static ones. This exposes the full 96-entry stacked pool, so frame bases near 95 make the modulo wrap back to physical 32. Rotating counts of up to 96 entries become reachable, and random markers cover a frame size of 0 as well as full 96-entry frames. Directed cases cover the rotation base wrapping from 0, a load that overrides a rotate, and suppressed writes outside the frame.

// File: rtl/gfm_pkg.sv
package gfm_pkg;
  localparam int unsigned MARK_W = 38;

  typedef struct packed {
    logic [12:0] upper;
    logic [6:0]  rrb;
    logic [3:0]  sor;
    logic [6:0]  sol;
    logic [6:0]  sof;
  } marker_t;
endpackage

// File: rtl/gfm_xlate.sv
module gfm_xlate
  import gfm_pkg::*;
#(
  parameter int unsigned NREG    = 128,
  parameter int unsigned NSTATIC = 32,
  localparam int unsigned IDX_W  = $clog2(NREG),
  localparam int unsigned NSTACK = NREG - NSTATIC
) (
  input  logic [IDX_W-1:0] lreg_i,
  input  marker_t          mk_i,
  input  logic [IDX_W-1:0] fbase_i,
  output logic [IDX_W-1:0] preg_o,
  output logic             oob_o
);
  logic [IDX_W:0] off, rot_cnt, rsum, roff, fsum;
  logic           is_static;

  always_comb begin
    is_static = lreg_i < IDX_W'(NSTATIC);
    off       = {1'b0, lreg_i} - (IDX_W+1)'(NSTATIC);
    rot_cnt   = (IDX_W+1)'({mk_i.sor, 3'b000});
    oob_o     = !is_static && (off >= (IDX_W+1)'(mk_i.sof));
    // rotating region renamed before frame base offset
    rsum = off + (IDX_W+1)'(mk_i.rrb);
    if (rsum >= rot_cnt) rsum = rsum - rot_cnt;
    roff = (off < rot_cnt) ? rsum : off;
    fsum = (IDX_W+1)'(fbase_i) + roff;
    if (fsum >= (IDX_W+1)'(NSTACK)) fsum = fsum - (IDX_W+1)'(NSTACK);
    preg_o = is_static ? lreg_i : IDX_W'(fsum + (IDX_W+1)'(NSTATIC));
  end
endmodule

// File: rtl/gfm_marker.sv
module gfm_marker
  import gfm_pkg::*;
#(
  parameter int unsigned IDX_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  marker_t          mk_i,
  input  logic [IDX_W-1:0] fbase_i,
  input  logic             rot_i,
  output marker_t          mk_o,
  output logic [IDX_W-1:0] fbase_o
);
  logic [7:0] rot_cnt;
  assign rot_cnt = {1'b0, mk_o.sor, 3'b000};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mk_o    <= '0;
      fbase_o <= '0;
    end else if (ld_i) begin
      mk_o    <= mk_i;
      fbase_o <= fbase_i;
    end else if (rot_i && (mk_o.sor != 4'd0)) begin
      mk_o.rrb <= (mk_o.rrb == 7'd0) ? 7'(rot_cnt - 8'd1) : mk_o.rrb - 7'd1;
    end
  end
endmodule

// File: rtl/gfm_rf.sv
module gfm_rf #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned NREG   = 128,
  parameter int unsigned NRD    = 2,
  localparam int unsigned IDX_W = $clog2(NREG)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NRD-1:0][IDX_W-1:0]   raddr_i,
  output logic [NRD-1:0][DATA_W-1:0]  rdata_o,
  output logic [NRD-1:0]              rnat_o,
  input  logic                        we_i,
  input  logic [IDX_W-1:0]            waddr_i,
  input  logic [DATA_W-1:0]           wdata_i,
  input  logic                        wnat_i
);
  logic [DATA_W-1:0] mem [NREG];
  logic [NREG-1:0]   nat_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   nat_q <= '0;
    else if (we_i) nat_q[waddr_i] <= wnat_i;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata_o[g] = mem[raddr_i[g]];
    assign rnat_o[g]  = nat_q[raddr_i[g]];
  end
endmodule

// File: rtl/gr_frame_map.sv
module gr_frame_map
  import gfm_pkg::*;
#(
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned NREG    = 128,
  parameter int unsigned NSTATIC = 32,
  localparam int unsigned IDX_W  = $clog2(NREG),
  localparam int unsigned NPORT  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mk_ld_i,
  input  logic [MARK_W-1:0] marker_i,
  input  logic [IDX_W-1:0]  frame_base_i,
  input  logic              rotate_i,
  output logic [MARK_W-1:0] marker_o,
  input  logic [IDX_W-1:0]  ra_i,
  output logic [DATA_W-1:0] rdata_a_o,
  output logic              rnat_a_o,
  input  logic [IDX_W-1:0]  rb_i,
  output logic [DATA_W-1:0] rdata_b_o,
  output logic              rnat_b_o,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  wa_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wnat_i,
  output logic              illegal_o
);
  marker_t                         mk_q;
  logic [IDX_W-1:0]                fbase_q;
  logic [NPORT-1:0][IDX_W-1:0]     lidx, pidx;
  logic [NPORT-1:0]                oob;
  logic [1:0][DATA_W-1:0]          rf_data, rd_data;
  logic [1:0]                      rf_nat, rd_nat;
  logic                            we_eff;

  assign lidx = {wa_i, rb_i, ra_i};

  gfm_marker #(.IDX_W(IDX_W)) u_marker (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ld_i    (mk_ld_i),
    .mk_i    (marker_t'(marker_i)),
    .fbase_i (frame_base_i),
    .rot_i   (rotate_i),
    .mk_o    (mk_q),
    .fbase_o (fbase_q)
  );

  for (genvar g = 0; g < NPORT; g++) begin : g_xl
    gfm_xlate #(.NREG(NREG), .NSTATIC(NSTATIC)) u_xlate (
      .lreg_i  (lidx[g]),
      .mk_i    (mk_q),
      .fbase_i (fbase_q),
      .preg_o  (pidx[g]),
      .oob_o   (oob[g])
    );
  end

  assign we_eff = we_i && !oob[2] && (wa_i != '0);

  gfm_rf #(.DATA_W(DATA_W), .NREG(NREG), .NRD(2)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .raddr_i (pidx[1:0]),
    .rdata_o (rf_data),
    .rnat_o  (rf_nat),
    .we_i    (we_eff),
    .waddr_i (pidx[2]),
    .wdata_i (wdata_i),
    .wnat_i  (wnat_i)
  );

  for (genvar g = 0; g < 2; g++) begin : g_rsel
    always_comb begin
      if (lidx[g] == '0) begin
        rd_data[g] = '0;
        rd_nat[g]  = 1'b0;
      end else if (oob[g]) begin
        rd_data[g] = '0;
        rd_nat[g]  = 1'b1;
      end else begin
        rd_data[g] = rf_data[g];
        rd_nat[g]  = rf_nat[g];
      end
    end
  end

  assign rdata_a_o = rd_data[0];
  assign rnat_a_o  = rd_nat[0];
  assign rdata_b_o = rd_data[1];
  assign rnat_b_o  = rd_nat[1];
  assign illegal_o = oob[0] | oob[1] | (we_i & oob[2]);
  assign marker_o  = mk_q;
endmodule

// File: rtl/gfm_chk.sv
module gfm_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        mk_ld_i,
  input logic [37:0] marker_i,
  input logic        rotate_i,
  input logic [37:0] marker_o,
  input logic [6:0]  ra_i,
  input logic [63:0] rdata_a_o,
  input logic        rnat_a_o,
  input logic        illegal_o
);
  logic a_oob;
  assign a_oob = (ra_i >= 7'd32) && ((ra_i - 7'd32) >= marker_o[6:0]);

  p_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ra_i == 7'd0) |-> (rdata_a_o == 64'd0 && !rnat_a_o));

  p_oob_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_oob |-> (rdata_a_o == 64'd0 && rnat_a_o && illegal_o));

  p_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mk_ld_i |=> (marker_o == $past(marker_i)));

  p_rot_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rotate_i && !mk_ld_i && marker_o[17:14] != 4'd0) |=>
      (marker_o[24:18] == (($past(marker_o[24:18]) == 7'd0) ?
        7'({$past(marker_o[17:14]), 3'b000} - 7'd1) : $past(marker_o[24:18]) - 7'd1)));

  p_rot_keep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mk_ld_i |=> (marker_o[17:0] == $past(marker_o[17:0]) &&
                  marker_o[37:25] == $past(marker_o[37:25])));
endmodule

bind gr_frame_map gfm_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mk_ld_i   (mk_ld_i),
  .marker_i  (marker_i),
  .rotate_i  (rotate_i),
  .marker_o  (marker_o),
  .ra_i      (ra_i),
  .rdata_a_o (rdata_a_o),
  .rnat_a_o  (rnat_a_o),
  .illegal_o (illegal_o)
);

// File: tb/gr_frame_map_tb_top.sv
module gr_frame_map_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mk_ld_i = 1'b0, rotate_i = 1'b0, we_i = 1'b0, wnat_i = 1'b0;
  logic [37:0] marker_i = '0;
  logic [6:0]  frame_base_i = '0, ra_i = '0, rb_i = '0, wa_i = '0;
  logic [63:0] wdata_i = '0;
  logic [37:0] marker_o;
  logic [63:0] rdata_a_o, rdata_b_o;
  logic        rnat_a_o, rnat_b_o, illegal_o;

  int checks = 0, failures = 0;
  logic [63:0] ref_d [128];
  logic        ref_n [128];
  logic [37:0] m_mk = '0;
  int          m_fb = 0;

  always #10 clk = ~clk;

  gr_frame_map dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .mk_ld_i(mk_ld_i), .marker_i(marker_i),
    .frame_base_i(frame_base_i), .rotate_i(rotate_i), .marker_o(marker_o),
    .ra_i(ra_i), .rdata_a_o(rdata_a_o), .rnat_a_o(rnat_a_o),
    .rb_i(rb_i), .rdata_b_o(rdata_b_o), .rnat_b_o(rnat_b_o),
    .we_i(we_i), .wa_i(wa_i), .wdata_i(wdata_i), .wnat_i(wnat_i),
    .illegal_o(illegal_o));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int map_ref(input int r, input logic [37:0] mk, input int fb);
    int off, cnt;
    if (r < 32) return r;
    off = r - 32;
    if (off >= int'(mk[6:0])) return -1;
    cnt = int'(mk[17:14]) * 8;
    if (off < cnt) off = (off + int'(mk[24:18])) % cnt;
    return 32 + (fb + off) % 96;
  endfunction

  function automatic string req_of(input int r, input logic [37:0] mk);
    if (r == 0) return "R2";
    if (r < 32) return "R3";
    if (map_ref(r, mk, 0) < 0) return "R6";
    if (r - 32 < int'(mk[17:14]) * 8) return "R5";
    return "R4";
  endfunction

  task automatic chk_port(input int r, input logic [63:0] d, input logic n, input string nm);
    int p;
    logic [63:0] ed;
    logic en;
    p = map_ref(r, m_mk, m_fb);
    if (r == 0) begin ed = '0; en = 1'b0; end
    else if (p < 0) begin ed = '0; en = 1'b1; end
    else begin ed = ref_d[p]; en = ref_n[p]; end
    // R1 / R10: reads before the edge see pre-write contents
    chk(d === ed, req_of(r, m_mk), {nm, " data"}, d, ed);
    chk(n === en, req_of(r, m_mk), {nm, " nat"}, 64'(n), 64'(en));
  endtask

  task automatic step(input bit ld, input logic [37:0] mk, input int fb, input bit rot,
                      input bit we, input int wa, input logic [63:0] wd, input bit wn,
                      input int ra, input int rb);
    int pw;
    bit eill;
    logic [4:0] cnt5;
    mk_ld_i = ld; marker_i = mk; frame_base_i = 7'(fb); rotate_i = rot;
    we_i = we; wa_i = 7'(wa); wdata_i = wd; wnat_i = wn; ra_i = 7'(ra); rb_i = 7'(rb);
    #2;
    chk_port(ra, rdata_a_o, rnat_a_o, "port A");
    chk_port(rb, rdata_b_o, rnat_b_o, "port B");
    pw = map_ref(wa, m_mk, m_fb);
    eill = (map_ref(ra, m_mk, m_fb) < 0) || (map_ref(rb, m_mk, m_fb) < 0) || (we && pw < 0);
    chk(illegal_o === eill, "R6", "illegal flag", 64'(illegal_o), 64'(eill));
    chk(marker_o === m_mk, "R7", "marker", 64'(marker_o), 64'(m_mk));
    @(posedge clk);
    if (we && wa != 0 && pw >= 0) begin ref_d[pw] = wd; ref_n[pw] = wn; end
    if (ld) begin m_mk = mk; m_fb = fb; end
    else if (rot && m_mk[17:14] != 4'd0) begin
      cnt5 = 5'(m_mk[17:14]);
      m_mk[24:18] = (m_mk[24:18] == 7'd0) ? 7'(int'(cnt5) * 8 - 1) : m_mk[24:18] - 7'd1;
    end
    @(negedge clk);
  endtask

  function automatic logic [37:0] mk_make(input int sof, input int sor, input int rrb);
    logic [37:0] m;
    m = '0;
    m[6:0] = 7'(sof); m[17:14] = 4'(sor); m[24:18] = 7'(rrb);
    return m;
  endfunction

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [37:0] full, mk;
    void'($urandom(32'd4711));
    for (int i = 0; i < 128; i++) begin ref_d[i] = '0; ref_n[i] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #2;
    // R9: reset state
    chk(marker_o === 38'd0, "R9", "marker after reset", 64'(marker_o), 64'd0);
    ra_i = 7'd40; #1;
    chk(rdata_a_o === 64'd0 && rnat_a_o === 1'b1 && illegal_o === 1'b1, "R9",
        "stacked out of frame after reset", {rdata_a_o[61:0], rnat_a_o, illegal_o}, 64'd3);
    ra_i = 7'd3; #1;
    chk(rnat_a_o === 1'b0, "R9", "nat cleared", 64'(rnat_a_o), 64'd0);
    @(negedge clk);

    // fill: full frame, base 0, no rotation -> identity map (R1)
    full = mk_make(96, 0, 0);
    step(1, full, 0, 0, 0, 0, 0, 0, 0, 0);
    for (int r = 1; r < 128; r++)
      step(0, full, 0, 0, 1, r, {$urandom(), $urandom()}, 1'(r % 5 == 0), r - 1, 0);

    // R2: write to register 0 is discarded
    step(0, full, 0, 0, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, 0);
    chk(rdata_a_o === 64'd0, "R2", "reg0 after write", rdata_a_o, 64'd0);

    // R4: frame base wrap, base 90 offset 8 -> physical 34
    step(1, full, 90, 0, 0, 0, 0, 0, 0, 0);
    step(0, full, 90, 0, 1, 40, 64'hA5A5_0000_1234_5678, 1, 40, 5);
    step(1, full, 0, 0, 0, 0, 0, 0, 34, 0);
    step(0, full, 0, 0, 0, 0, 0, 0, 34, 5);
    chk(rdata_a_o === 64'hA5A5_0000_1234_5678 && rnat_a_o === 1'b1, "R4",
        "wrapped frame base", rdata_a_o, 64'hA5A5_0000_1234_5678);

    // R8: rotation base wraps 0 -> count-1, then steps down
    mk = mk_make(16, 1, 0);
    step(1, mk, 0, 0, 0, 0, 0, 0, 0, 0);
    step(0, mk, 0, 1, 0, 0, 0, 0, 33, 40);
    chk(marker_o[24:18] === 7'd7, "R8", "rotation base wrap", 64'(marker_o[24:18]), 64'd7);
    step(0, mk, 0, 1, 0, 0, 0, 0, 33, 32);
    chk(marker_o[24:18] === 7'd6, "R8", "rotation base step", 64'(marker_o[24:18]), 64'd6);
    // R5: offset 1 + 6 = 7 -> physical 39
    chk(rdata_a_o === ref_d[39], "R5", "rotated read", rdata_a_o, ref_d[39]);
    // R7: load beats rotate
    step(1, mk_make(24, 2, 5), 3, 1, 0, 0, 0, 0, 33, 50);
    chk(marker_o[24:18] === 7'd5, "R7", "load over rotate", 64'(marker_o[24:18]), 64'd5);
    // R8: count 0 -> rotate ignored
    step(1, mk_make(20, 0, 0), 0, 0, 0, 0, 0, 0, 0, 0);
    step(0, mk, 0, 1, 0, 0, 0, 0, 0, 0);
    chk(marker_o === mk_make(20, 0, 0), "R8", "rotate with zero count", 64'(marker_o), 64'(mk_make(20, 0, 0)));

    // R6: write above the frame is suppressed
    step(1, mk_make(4, 0, 0), 0, 0, 0, 0, 0, 0, 0, 0);
    step(0, mk, 0, 0, 1, 60, 64'hDEAD_BEEF_DEAD_BEEF, 0, 60, 1);
    chk(illegal_o === 1'b1, "R6", "illegal on write", 64'(illegal_o), 64'd1);
    step(1, full, 0, 0, 0, 0, 0, 0, 0, 0);
    step(0, full, 0, 0, 0, 0, 0, 0, 60, 1);
    chk(rdata_a_o === ref_d[60], "R6", "suppressed write", rdata_a_o, ref_d[60]);

    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      int sof, sor, cnt, rrb, ra, rb, wa;
      bit ld;
      ld = ($urandom_range(0, 15) == 0);
      sof = $urandom_range(0, 96);
      sor = $urandom_range(0, (sof / 8 > 12) ? 12 : sof / 8);
      cnt = sor * 8;
      rrb = (cnt != 0) ? $urandom_range(0, cnt - 1) : 0;
      mk = mk_make(sof, sor, rrb);
      mk[13:7] = 7'($urandom_range(0, sof));
      mk[37:25] = 13'($urandom());
      ra = ($urandom_range(0, 1) != 0) ? 32 + $urandom_range(0, int'(m_mk[6:0])) : $urandom_range(0, 127);
      rb = $urandom_range(0, 127);
      wa = ($urandom_range(0, 3) != 0) ? 32 + $urandom_range(0, int'(m_mk[6:0])) : $urandom_range(0, 127);
      if (ra > 127) ra = 127;
      if (wa > 127) wa = 127;
      step(ld, mk, $urandom_range(0, 95), 1'($urandom_range(0, 7) == 0),
           1'($urandom_range(0, 1)), wa, {$urandom(), $urandom()}, 1'($urandom_range(0, 1)),
           ra, rb);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule